// File: doc/BRIEF.md
# Cascaded Interrupt Encoder

This block collects interrupt requests from three groups (critical, main and peripheral) and condenses them into one 32-bit encoded status word. Each group gets a valid flag and a source-number field, so an interrupt handler reads a single word and knows which source to serve in each group. The main and peripheral groups are gated by mask registers in which a 1 disables a source. The critical group has no mask.

Two reserved numbers link the groups. Critical number 2 and main number 4 do not come from external lines. They report that a high-priority or a low-priority peripheral is pending, and software then goes to the peripheral field. Peripheral number 0 is also internal. It stands for a 32-line secondary controller that has its own sticky pending register, cleared by writing 1s, and its own mask register. A small register port reads the status word and reads and writes the masks and the secondary pending register. The high-priority set of peripherals is fixed by a parameter. By default it is sources 4 and 5.

Top module: `cie_encoder`

## Requirements
- R1: Status bit 10 flags a pending critical source and bits 9:8 hold its number. The critical group has no mask and takes external lines 0, 1 and 3.
- R2: Status bit 21 flags a pending main source and bits 20:16 hold its number. Main source n is disabled while bit (16 − n) of the main mask (address 1) is 1.
- R3: Status bit 29 flags a pending peripheral and bits 28:24 hold its number. Peripheral n is disabled while bit (31 − n) of the peripheral mask (address 2) is 1.
- R4: Critical number 2 is reported exactly when an unmasked high-priority peripheral is pending. The peripheral field then holds the lowest such high-priority peripheral. External critical line 2 has no effect.
- R5: Main number 4 is reported when an unmasked low-priority peripheral is pending and main-mask bit 12 is 0. External main line 4 has no effect.
- R6: Within each group the lowest pending unmasked number wins. The one exception is the peripheral field, which prefers high-priority peripherals.
- R7: A group with nothing pending and unmasked reports valid flag 0 and number field 0.
- R8: A secondary pending bit (address 3, bit n for line n) is set in any cycle its request is high and stays set until 1 is written to it. Writing all ones clears every bit whose request is low.
- R9: Peripheral 0 is pending exactly when some secondary pending bit is set with its secondary-mask bit (address 4, bit n, 1 = disabled) at 0. External peripheral line 0 has no effect.
- R10: After reset the main mask reads 0x0001FFFF, the peripheral mask reads 0xFFFFFF00, the secondary mask reads 0xFFFFFFFF, and the secondary pending register and the status word read 0.
- R11: The status word is registered. It reflects inputs and register state one clock later and is read at address 0. Writes to address 0 and to unimplemented mask bits have no effect, those bits read 0, and status bits outside the three fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| crit_req | input | 4 | Critical request lines; line 2 is unused |
| main_req | input | NUM_MAIN | Main request lines; line 4 is unused |
| per_req | input | NUM_PER | Peripheral request lines; line 0 is unused |
| sec_req | input | SEC_N | Secondary controller request lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 status, 1 main mask, 2 peripheral mask, 3 secondary pending, 4 secondary mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| status_o | output | 32 | Encoded status word |

## Verification
The embedded properties check the cross-group links on every cycle. Whenever critical number 2 or main number 4 is reported, the peripheral field must be valid, and in the critical case it must name a high-priority peripheral. A reported main or peripheral number must have been unmasked in the cycle it was encoded. The secondary pending bits must capture every request and empty after an all-ones clear. The scenarios show what properties cannot: that the lowest number wins, which external reserved lines are ignored, the reset values of the registers, the one-cycle latency of the status word and the bits that read as zero. A cycle-accurate model checks every field of the word on every clock.

// File: rtl/cie_pkg.sv
package cie_pkg;
  localparam int STAT_W       = 32;
  localparam int NUM_W        = 5;
  localparam int CRIT_N       = 4;
  localparam int CRIT_W       = 2;
  localparam int CRIT_CASCADE = 2;
  localparam int MAIN_CASCADE = 4;
  localparam int PER_CASCADE  = 0;

  localparam int CV_BIT = 10;
  localparam int CN_LSB = 8;
  localparam int MV_BIT = 21;
  localparam int MN_LSB = 16;
  localparam int PV_BIT = 29;
  localparam int PN_LSB = 24;

  typedef enum logic [2:0] {
    REG_STATUS    = 3'd0,
    REG_MAIN_MASK = 3'd1,
    REG_PER_MASK  = 3'd2,
    REG_SEC_PEND  = 3'd3,
    REG_SEC_MASK  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cie_pick.sv
module cie_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign valid = |req;
endmodule

// File: rtl/cie_sec.sv
module cie_sec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] req,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         any_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] mask_q, mask_d;
  logic [N-1:0] clr_vec;
  logic         alive_q;

  always_comb begin
    clr_vec = clr_we ? wdata : '0;
    pend_d  = (pend_q & ~clr_vec) | req;
    mask_d  = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mask_q  <= '1;
      alive_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      alive_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign any_o  = |(pend_q & ~mask_q);

  // R8: every request seen is captured in the pending register
  p_sec_capture_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    alive_q |=> ((pend_q & $past(req)) == $past(req)));

  // R8: an all-ones clear with no request empties the register
  p_sec_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (alive_q && clr_we && (&wdata) && !(|req)) |=> (pend_q == '0));
endmodule

// File: rtl/cie_encoder.sv
module cie_encoder
  import cie_pkg::*;
#(
  parameter int          NUM_MAIN = 17,
  parameter int          NUM_PER  = 24,
  parameter int          SEC_N    = 32,
  parameter logic [31:0] PER_HI   = 32'h0000_0030
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CRIT_N-1:0]   crit_req,
  input  logic [NUM_MAIN-1:0] main_req,
  input  logic [NUM_PER-1:0]  per_req,
  input  logic [SEC_N-1:0]    sec_req,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [31:0]         status_o
);
  localparam int MAIN_SHIFT = 17 - NUM_MAIN;
  localparam int PER_SHIFT  = 32 - NUM_PER;
  localparam logic [NUM_PER-1:0] HI_VEC = PER_HI[NUM_PER-1:0];

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // register port decode
  logic main_mask_en, per_mask_en, sec_clr_en, sec_mask_en;
  always_comb begin
    main_mask_en = reg_wr_en && (reg_addr == REG_MAIN_MASK);
    per_mask_en  = reg_wr_en && (reg_addr == REG_PER_MASK);
    sec_clr_en   = reg_wr_en && (reg_addr == REG_SEC_PEND);
    sec_mask_en  = reg_wr_en && (reg_addr == REG_SEC_MASK);
  end

  // mask registers, stored in register bit order
  logic [NUM_MAIN-1:0] main_mask_q, main_mask_d;
  logic [NUM_PER-1:0]  per_mask_q, per_mask_d;
  logic [STAT_W-1:0]   status_q, status_d;

  always_comb begin
    main_mask_d = main_mask_en ? reg_wdata[16 -: NUM_MAIN] : main_mask_q;
    per_mask_d  = per_mask_en  ? reg_wdata[31 -: NUM_PER]  : per_mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      main_mask_q <= '1;
      per_mask_q  <= '1;
      status_q    <= '0;
    end else begin
      main_mask_q <= main_mask_d;
      per_mask_q  <= per_mask_d;
      status_q    <= status_d;
    end
  end

  // secondary controller behind peripheral 0
  logic [SEC_N-1:0] sec_pend, sec_mask;
  logic             sec_any;

  cie_sec #(.N(SEC_N)) u_sec (
    .clk    (clk),
    .rst_ni (rst_ni),
    .req    (sec_req),
    .clr_we (sec_clr_en),
    .mask_we(sec_mask_en),
    .wdata  (reg_wdata[SEC_N-1:0]),
    .pend_o (sec_pend),
    .mask_o (sec_mask),
    .any_o  (sec_any)
  );

  // source-ordered disables and raw requests
  logic [NUM_MAIN-1:0] main_dis, main_raw;
  logic [NUM_PER-1:0]  per_dis, per_raw;
  logic                per_lo_any;

  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main
    assign main_dis[n] = main_mask_q[NUM_MAIN-1-n];
    if (n == MAIN_CASCADE) begin : g_casc
      assign main_raw[n] = per_lo_any;
    end else begin : g_ext
      assign main_raw[n] = main_req[n];
    end
  end

  for (genvar n = 0; n < NUM_PER; n++) begin : g_per
    assign per_dis[n] = per_mask_q[NUM_PER-1-n];
    if (n == PER_CASCADE) begin : g_casc
      assign per_raw[n] = sec_any;
    end else begin : g_ext
      assign per_raw[n] = per_req[n];
    end
  end

  // peripheral group
  logic [NUM_PER-1:0] per_live;
  logic               per_hi_v, per_all_v;
  logic [NUM_W-1:0]   per_hi_idx, per_all_idx, per_num;

  assign per_live   = per_raw & ~per_dis;
  assign per_lo_any = |(per_live & ~HI_VEC);

  cie_pick #(.N(NUM_PER), .IW(NUM_W)) u_pick_per_hi (
    .req(per_live & HI_VEC), .valid(per_hi_v), .idx(per_hi_idx));
  cie_pick #(.N(NUM_PER), .IW(NUM_W)) u_pick_per_all (
    .req(per_live), .valid(per_all_v), .idx(per_all_idx));

  assign per_num = per_hi_v ? per_hi_idx : per_all_idx;

  // critical group: slot 2 reports a high-priority peripheral
  logic [CRIT_N-1:0] crit_eff;
  logic              crit_v;
  logic [CRIT_W-1:0] crit_idx;

  for (genvar c = 0; c < CRIT_N; c++) begin : g_crit
    if (c == CRIT_CASCADE) begin : g_casc
      assign crit_eff[c] = per_hi_v;
    end else begin : g_ext
      assign crit_eff[c] = crit_req[c];
    end
  end

  cie_pick #(.N(CRIT_N), .IW(CRIT_W)) u_pick_crit (
    .req(crit_eff), .valid(crit_v), .idx(crit_idx));

  // main group
  logic             main_v;
  logic [NUM_W-1:0] main_idx;

  cie_pick #(.N(NUM_MAIN), .IW(NUM_W)) u_pick_main (
    .req(main_raw & ~main_dis), .valid(main_v), .idx(main_idx));

  always_comb begin
    status_d                     = '0;
    status_d[CV_BIT]             = crit_v;
    status_d[CN_LSB +: CRIT_W]   = crit_idx;
    status_d[MV_BIT]             = main_v;
    status_d[MN_LSB +: NUM_W]    = main_idx;
    status_d[PV_BIT]             = per_all_v;
    status_d[PN_LSB +: NUM_W]    = per_num;
  end

  // read mux
  always_comb begin
    case (reg_addr)
      REG_STATUS:    reg_rdata = status_q;
      REG_MAIN_MASK: reg_rdata = 32'(main_mask_q) << MAIN_SHIFT;
      REG_PER_MASK:  reg_rdata = 32'(per_mask_q) << PER_SHIFT;
      REG_SEC_PEND:  reg_rdata = 32'(sec_pend);
      REG_SEC_MASK:  reg_rdata = 32'(sec_mask);
      default:       reg_rdata = '0;
    endcase
  end

  assign status_o = status_q;

  logic unused_bits;
  assign unused_bits = ^{crit_req[CRIT_CASCADE], main_req[MAIN_CASCADE],
                         per_req[PER_CASCADE], reg_wdata};

  // checks across the encoder, the masks and the status register
  logic main_hit_dis, per_hit_dis;
  assign main_hit_dis = main_dis[main_idx];
  assign per_hit_dis  = per_dis[per_num];

  // R2: a reported main number was unmasked when it was encoded
  p_main_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    status_q[MV_BIT] |-> !$past(main_hit_dis));

  // R3: a reported peripheral number was unmasked when it was encoded
  p_per_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    status_q[PV_BIT] |-> !$past(per_hit_dis));

  // R4: critical slot 2 points at a valid high-priority peripheral
  p_crit_hi_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_q[CV_BIT] && status_q[CN_LSB +: CRIT_W] == 2'(CRIT_CASCADE))
      |-> (status_q[PV_BIT] && HI_VEC[status_q[PN_LSB +: NUM_W]]));

  // R5: main slot 4 always comes with a valid peripheral field
  p_main_lo_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_q[MV_BIT] && status_q[MN_LSB +: NUM_W] == 5'(MAIN_CASCADE))
      |-> status_q[PV_BIT]);
endmodule

// File: tb/tb_cie_encoder.sv
module tb_cie_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MAIN = 17;
  localparam int NUM_PER  = 24;
  localparam int SEC_N    = 32;
  localparam logic [31:0] HI = 32'h0000_0030;

  logic                clk;
  logic                rst_n;
  logic [3:0]          crit_req;
  logic [NUM_MAIN-1:0] main_req;
  logic [NUM_PER-1:0]  per_req;
  logic [SEC_N-1:0]    sec_req;
  logic                reg_wr_en;
  logic [2:0]          reg_addr;
  logic [31:0]         reg_wdata;
  logic [31:0]         reg_rdata;
  logic [31:0]         status_o;

  cie_encoder dut (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
    .per_req(per_req), .sec_req(sec_req), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_o(status_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [16:0] m_mmask;
  logic [31:0] m_pmask, m_spend, m_smask, m_stat;
  int          live = 0;

  always @(posedge clk) begin : model
    int hi, any, cs, ms;
    bit lo, p0, pend, r;
    logic [3:0]  c;
    logic [31:0] ns, clr;
    if (!rst_n || live < 3) begin
      if (!rst_n) live = 0; else live++;
      m_mmask = 17'h1FFFF; m_pmask = 32'hFFFFFF00;
      m_spend = 0; m_smask = 32'hFFFFFFFF; m_stat = 0;
    end else begin
      hi = -1; any = -1; lo = 0;
      p0 = |(m_spend & ~m_smask);
      for (int n = 0; n < NUM_PER; n++) begin
        pend = (n == 0) ? p0 : per_req[n];
        if (pend && !m_pmask[31-n]) begin
          if (any < 0) any = n;
          if (HI[n]) begin if (hi < 0) hi = n; end
          else lo = 1;
        end
      end
      c = {crit_req[3], hi >= 0, crit_req[1:0]};
      cs = -1;
      for (int n = 3; n >= 0; n--) if (c[n]) cs = n;
      ms = -1;
      for (int n = NUM_MAIN - 1; n >= 0; n--) begin
        r = (n == 4) ? lo : main_req[n];
        if (r && !m_mmask[16-n]) ms = n;
      end
      ns = 0;
      if (cs >= 0)  ns = ns | 32'h400 | (32'(cs) << 8);
      if (ms >= 0)  ns = ns | 32'h200000 | (32'(ms) << 16);
      if (any >= 0) ns = ns | 32'h20000000 | (32'((hi >= 0) ? hi : any) << 24);
      clr = 0;
      if (reg_wr_en) begin
        case (reg_addr)
          3'd1: m_mmask = reg_wdata[16:0];
          3'd2: m_pmask = reg_wdata & 32'hFFFFFF00;
          3'd3: clr = reg_wdata;
          3'd4: m_smask = reg_wdata;
          default: ;
        endcase
      end
      m_spend = (m_spend & ~clr) | sec_req;
      m_stat  = ns;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && live >= 3 && !done) begin
      chk("R1",  "critical field",  status_o & 32'h00000700, m_stat & 32'h00000700);
      chk("R2",  "main field",      status_o & 32'h003F0000, m_stat & 32'h003F0000);
      chk("R3",  "peripheral field",status_o & 32'h3F000000, m_stat & 32'h3F000000);
      chk("R11", "reserved bits",   status_o & ~32'h3F3F0700, 32'h0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 3'd0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; crit_req = '0; main_req = '0; per_req = '0; sec_req = '0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(6);

    // R10 reset values
    rd(3'd0, v); chk("R10", "status after reset", v, 32'h0);
    chk("R10", "status port after reset", status_o, 32'h0);
    rd(3'd1, v); chk("R10", "main mask reset", v, 32'h0001FFFF);
    rd(3'd2, v); chk("R10", "peripheral mask reset", v, 32'hFFFFFF00);
    rd(3'd3, v); chk("R10", "secondary pending reset", v, 32'h0);
    rd(3'd4, v); chk("R10", "secondary mask reset", v, 32'hFFFFFFFF);

    // R1 / R6 critical group, lowest wins
    crit_req = 4'b1010; tick(1);
    chk("R6", "critical lowest of 1 and 3", status_o, 32'h00000500);
    crit_req = 4'b1000; tick(1);
    chk("R1", "critical source 3", status_o, 32'h00000700);
    crit_req = 4'b0100; tick(1);
    chk("R4", "external critical line 2 ignored", status_o, 32'h0);
    crit_req = 4'b0000;

    // R2 main group masking
    main_req = 17'((1 << 3) | (1 << 9)); tick(1);
    chk("R2", "masked main sources hidden", status_o, 32'h0);
    wr(3'd1, 32'h0001DF7F); tick(1);
    chk("R6", "main lowest of 3 and 9", status_o, 32'h00230000);
    rd(3'd1, v); chk("R2", "main mask readback", v, 32'h0001DF7F);
    main_req = 17'(1 << 9); tick(1);
    chk("R2", "main source 9", status_o, 32'h00290000);
    main_req = 17'(1 << 4); tick(1);
    chk("R5", "external main line 4 ignored", status_o, 32'h0);
    main_req = '0;
    wr(3'd1, 32'hFFFFFFFF);
    rd(3'd1, v); chk("R11", "unimplemented main mask bits read 0", v, 32'h0001FFFF);
    wr(3'd0, 32'hFFFFFFFF); tick(1);
    rd(3'd0, v); chk("R11", "status write ignored", v, 32'h0);
    chk("R7", "empty groups read zero", status_o, 32'h0);

    // R3 / R4 / R5 peripheral group and cascade slots
    per_req = 24'((1 << 3) | (1 << 5));
    wr(3'd2, 32'hEBFFFF00); tick(1);
    chk("R4", "high-priority peripheral via critical 2", status_o, 32'h25000600);
    wr(3'd1, 32'h0001EFFF); tick(1);
    chk("R5", "low-priority peripheral via main 4", status_o, 32'h25240600);
    per_req = 24'(1 << 3); tick(1);
    chk("R3", "low-priority peripheral 3 only", status_o, 32'h23240000);
    per_req = 24'(1 << 5); tick(1);
    chk("R4", "high-priority peripheral 5 only", status_o, 32'h25000600);
    per_req = 24'h1; tick(1);
    chk("R9", "external peripheral line 0 ignored", status_o, 32'h0);
    per_req = '0;

    // R8 / R9 secondary controller
    wr(3'd2, 32'h6BFFFF00);
    wr(3'd4, 32'hFFFFFF7F);
    sec_req = 32'h00000280; tick(1);
    sec_req = '0; tick(1);
    chk("R9", "unmasked secondary line reaches peripheral 0", status_o, 32'h20240000);
    rd(3'd3, v); chk("R8", "secondary pending sticky", v, 32'h00000280);
    wr(3'd3, 32'h00000080); tick(1);
    rd(3'd3, v); chk("R8", "write-one clears single bit", v, 32'h00000200);
    chk("R9", "masked secondary line hidden", status_o, 32'h0);
    sec_req = 32'hFFFF0000; tick(1);
    sec_req = '0;
    rd(3'd3, v); chk("R8", "multiple secondary bits set", v, 32'hFFFF0200);
    wr(3'd3, 32'hFFFFFFFF);
    rd(3'd3, v); chk("R8", "all-ones write clears all", v, 32'h0);
    tick(2);
    chk("R7", "all groups idle", status_o, 32'h0);

    finish_run();
  end
endmodule